// File: doc/BRIEF.md
# Timed Interrupt Hold Counter

This block holds off mid-priority interrupts for a fixed number of instruction cycles. When the instruction decoder sees a timed-disable instruction it pulses a load strobe together with a count N. The block then asserts a per-level mask toward the interrupt arbiter for N+1 instruction cycles. Levels 1 to 6 are masked. Level 0 and level 7 are never masked, and traps are not touched. The count steps down once per enabled instruction cycle. A cycle-enable input lets stalled pipeline cycles pass without consuming hold time.

Software sees the remaining count and a hold-active status. While a hold is running, software may overwrite the count to lengthen or shorten it, and writing zero ends the hold at once. A software write cannot start a hold: when no hold is running the write is discarded.

Top module: `irq_hold_timer`

## Requirements
- R1: After reset the count output reads 0, the status output is low and every mask bit is low. Whenever the status output is low, the count output reads 0.
- R2: A load strobe with value N raises the status on the next cycle and shows N on the count output. With cycle-enable held high, the status then stays high for exactly N+1 sampled cycles, N=0 included. The count falls by one per enabled cycle.
- R3: While the status is high, mask bits 1 through 6 of the 8-bit level mask are set and bits 0 and 7 are clear. While the status is low, all mask bits are clear.
- R4: In a cycle with cycle-enable low and no strobe, the count output and the status output keep their values.
- R5: A software write with a nonzero value while the status is high replaces the count. From then on the hold lasts value+1 more enabled cycles.
- R6: A software write while the status is low has no effect: the count output stays 0 and the status stays low.
- R7: A software write of zero while the status is high clears the status on the next cycle.
- R8: When a load strobe and a software write occur in the same cycle, the load value is taken and the write is discarded.
- R9: A load strobe while a hold is already running restarts the hold with the new value.
- R10: The count is 14 bits wide, so the largest load value 16383 gives a hold of 16384 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Load strobe from the instruction decoder |
| ld_val | input | 14 | Hold count N carried by the instruction |
| wr_stb | input | 1 | Software write strobe for the count |
| wr_val | input | 14 | Software write data |
| cyc_en | input | 1 | High in cycles that count as an executed instruction cycle |
| cnt_out | output | 14 | Remaining count, readable by software |
| hold_active | output | 1 | Status: the hold is running |
| lvl_mask | output | 8 | Per-priority-level mask toward the arbiter, bit k is level k |

## Verification
The checker tests these properties on every cycle: the mask band, the zero count while idle, the step-down by one, the hold during stalls, load priority over the write, replacement and cancel by a software write, and writes discarded while idle. Some behaviour needs a whole scenario to show: that a hold lasts exactly N+1 cycles, with N=0 and the full 16383 at the ends, and that a replaced count yields the right remaining length. The bench measures these durations from the ports and also runs a seeded random stream against its own model.

// File: rtl/irq_hold_pkg.sv
`timescale 1ns/1ps
package irq_hold_pkg;

    // Operation chosen for the count register in one cycle
    typedef enum logic [2:0] {
        HOP_IDLE   = 3'd0,
        HOP_LOAD   = 3'd1,
        HOP_WRITE  = 3'd2,
        HOP_CANCEL = 3'd3,
        HOP_TICK   = 3'd4
    } hold_op_e;

    // True when a priority level lies inside the masked band
    function automatic logic level_in_band(input int lvl, input int lo, input int hi);
        return (lvl >= lo) && (lvl <= hi);
    endfunction

endpackage

// File: rtl/irq_hold_arb.sv
`timescale 1ns/1ps
module irq_hold_arb
    import irq_hold_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             ld_stb,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             wr_stb,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             cyc_en,
    input  logic             active,
    output hold_op_e         op,
    output logic [CNT_W-1:0] op_val
);

    // Priority: instruction load, then software write, then decrement
    always_comb begin
        op     = HOP_IDLE;
        op_val = '0;
        if (ld_stb) begin
            op     = HOP_LOAD;
            op_val = ld_val;
        end else if (wr_stb && active) begin
            if (wr_val == '0) begin
                op = HOP_CANCEL;
            end else begin
                op     = HOP_WRITE;
                op_val = wr_val;
            end
        end else if (cyc_en && active) begin
            op = HOP_TICK;
        end
    end

endmodule

// File: rtl/irq_hold_count.sv
`timescale 1ns/1ps
module irq_hold_count
    import irq_hold_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  hold_op_e         op,
    input  logic [CNT_W-1:0] op_val,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else begin
            unique case (op)
                HOP_LOAD: begin
                    cnt    <= op_val;
                    active <= 1'b1;
                end
                HOP_WRITE: begin
                    cnt <= op_val;
                end
                HOP_CANCEL: begin
                    cnt    <= '0;
                    active <= 1'b0;
                end
                HOP_TICK: begin
                    if (cnt == '0) begin
                        active <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    cnt    <= cnt;
                    active <= active;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_hold_mask.sv
`timescale 1ns/1ps
module irq_hold_mask
    import irq_hold_pkg::*;
#(
    parameter int LVL_W   = 3,
    parameter int MASK_LO = 1,
    parameter int MASK_HI = 6,
    localparam int NLVL   = 1 << LVL_W
) (
    input  logic            active,
    output logic [NLVL-1:0] lvl_mask
);

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        if (level_in_band(k, MASK_LO, MASK_HI)) begin : g_band
            assign lvl_mask[k] = active;
        end else begin : g_open
            assign lvl_mask[k] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_hold_timer.sv
`timescale 1ns/1ps
module irq_hold_timer
    import irq_hold_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int LVL_W   = 3,
    parameter int MASK_LO = 1,
    parameter int MASK_HI = 6,
    localparam int NLVL   = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_stb,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             wr_stb,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             cyc_en,
    output logic [CNT_W-1:0] cnt_out,
    output logic             hold_active,
    output logic [NLVL-1:0]  lvl_mask
);

    hold_op_e         op;
    logic [CNT_W-1:0] op_val;
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    irq_hold_arb #(.CNT_W(CNT_W)) u_arb (
        .ld_stb (ld_stb),
        .ld_val (ld_val),
        .wr_stb (wr_stb),
        .wr_val (wr_val),
        .cyc_en (cyc_en),
        .active (act_q),
        .op     (op),
        .op_val (op_val)
    );

    irq_hold_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .op_val (op_val),
        .cnt    (cnt_q),
        .active (act_q)
    );

    irq_hold_mask #(
        .LVL_W   (LVL_W),
        .MASK_LO (MASK_LO),
        .MASK_HI (MASK_HI)
    ) u_mask (
        .active   (act_q),
        .lvl_mask (lvl_mask)
    );

    assign cnt_out     = cnt_q;
    assign hold_active = act_q;

endmodule

// File: rtl/irq_hold_timer_chk.sv
`timescale 1ns/1ps
module irq_hold_timer_chk #(
    parameter int CNT_W   = 14,
    parameter int LVL_W   = 3,
    parameter int MASK_LO = 1,
    parameter int MASK_HI = 6,
    localparam int NLVL   = 1 << LVL_W
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_stb,
    input logic [CNT_W-1:0] ld_val,
    input logic             wr_stb,
    input logic [CNT_W-1:0] wr_val,
    input logic             cyc_en,
    input logic [CNT_W-1:0] cnt_out,
    input logic             hold_active,
    input logic [NLVL-1:0]  lvl_mask
);

    localparam int BAND = MASK_HI - MASK_LO + 1;

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_active |-> cnt_out == '0);

    // R3
    mask_band_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lvl_mask) == (hold_active ? BAND : 0) && !lvl_mask[0] && !lvl_mask[NLVL-1]);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active && cyc_en && !ld_stb && !wr_stb && cnt_out != '0
        |=> hold_active && cnt_out == $past(cnt_out) - 1'b1);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en && !ld_stb && !wr_stb |=> $stable(cnt_out) && $stable(hold_active));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_stb |=> hold_active && cnt_out == $past(ld_val));

    // R5
    wr_replace_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active && wr_stb && !ld_stb && wr_val != '0
        |=> hold_active && cnt_out == $past(wr_val));

    // R7
    wr_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active && wr_stb && !ld_stb && wr_val == '0 |=> !hold_active);

    // R6
    wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_active && wr_stb && !ld_stb |=> !hold_active && cnt_out == '0);

endmodule

bind irq_hold_timer irq_hold_timer_chk #(
    .CNT_W   (CNT_W),
    .LVL_W   (LVL_W),
    .MASK_LO (MASK_LO),
    .MASK_HI (MASK_HI)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_stb      (ld_stb),
    .ld_val      (ld_val),
    .wr_stb      (wr_stb),
    .wr_val      (wr_val),
    .cyc_en      (cyc_en),
    .cnt_out     (cnt_out),
    .hold_active (hold_active),
    .lvl_mask    (lvl_mask)
);

// File: tb/test_irq_hold_timer.sv
`timescale 1ns/1ps
module test_irq_hold_timer;

    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst;
    logic          ld_stb, wr_stb, cyc_en;
    logic [CW-1:0] ld_val, wr_val;
    logic [CW-1:0] cnt_out;
    logic          hold_active;
    logic [7:0]    lvl_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench reference state
    int m_cnt = 0;
    bit m_act = 1'b0;

    always #2.5 clk = ~clk;

    irq_hold_timer i_irq_hold_timer (
        .clk         (clk),
        .rst         (rst),
        .ld_stb      (ld_stb),
        .ld_val      (ld_val),
        .wr_stb      (wr_stb),
        .wr_val      (wr_val),
        .cyc_en      (cyc_en),
        .cnt_out     (cnt_out),
        .hold_active (hold_active),
        .lvl_mask    (lvl_mask)
    );

    function automatic logic [7:0] exp_mask(input bit act);
        return act ? 8'b0111_1110 : 8'b0000_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(cnt_out == m_cnt[CW-1:0], {req, " count"}, cnt_out, m_cnt);
        chk(hold_active == m_act, {req, " status"}, hold_active, m_act);
        chk(lvl_mask == exp_mask(m_act), {req, " R3 mask"}, lvl_mask, exp_mask(m_act));
    endtask

    // one cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input bit ld, input int lv, input bit wr, input int wv, input bit en,
                       input string req);
        ld_stb = ld; ld_val = lv[CW-1:0];
        wr_stb = wr; wr_val = wv[CW-1:0];
        cyc_en = en;
        @(posedge clk);
        if (ld) begin
            m_cnt = lv; m_act = 1'b1;
        end else if (wr && m_act) begin
            if (wv == 0) begin m_cnt = 0; m_act = 1'b0; end
            else m_cnt = wv;
        end else if (en && m_act) begin
            if (m_cnt == 0) m_act = 1'b0;
            else m_cnt = m_cnt - 1;
        end
        @(negedge clk);
        cmp_all(req);
    endtask

    task automatic run_out(output int n, input string req);
        n = 0;
        while (hold_active && n < 20000) begin
            n++;
            cyc(0, 0, 0, 0, 1, req);
        end
    endtask

    initial begin
        #(300000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        rst = 1'b1; ld_stb = 0; wr_stb = 0; cyc_en = 0; ld_val = '0; wr_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_all("R1 reset");

        // R2: N=3 lasts 4 cycles
        cyc(1, 3, 0, 0, 1, "R2 load");
        run_out(n, "R2 run");
        chk(n == 4, "R2 duration N=3", n, 4);

        // R2: N=0 lasts 1 cycle
        cyc(1, 0, 0, 0, 1, "R2 load0");
        run_out(n, "R2 run0");
        chk(n == 1, "R2 duration N=0", n, 1);

        // R4: stalls freeze the count
        cyc(1, 5, 0, 0, 0, "R4 load");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R4 stall");
        chk(cnt_out == 5, "R4 held count", cnt_out, 5);
        run_out(n, "R4 run");
        chk(n == 6, "R4 duration after stall", n, 6);

        // R5: write extends / shortens
        cyc(1, 10, 0, 0, 1, "R5 load");
        cyc(0, 0, 0, 0, 1, "R5 tick");
        cyc(0, 0, 1, 2, 1, "R5 write");
        chk(cnt_out == 2, "R5 replaced count", cnt_out, 2);
        run_out(n, "R5 run");
        chk(n == 3, "R5 remaining duration", n, 3);

        // R6: write while idle ignored
        cyc(0, 0, 1, 7, 1, "R6 idle write");
        chk(!hold_active && cnt_out == 0, "R6 idle write ignored", hold_active, 0);
        cyc(0, 0, 0, 0, 1, "R6 after");

        // R7: write zero cancels
        cyc(1, 9, 0, 0, 1, "R7 load");
        cyc(0, 0, 1, 0, 1, "R7 cancel");
        chk(hold_active == 0, "R7 cancel clears status", hold_active, 0);

        // R8: load beats write
        cyc(1, 4, 1, 9, 1, "R8 both");
        chk(cnt_out == 4, "R8 load wins", cnt_out, 4);
        run_out(n, "R8 run");

        // R9: reload during hold
        cyc(1, 8, 0, 0, 1, "R9 load");
        cyc(0, 0, 0, 0, 1, "R9 tick");
        cyc(1, 2, 0, 0, 1, "R9 reload");
        chk(cnt_out == 2, "R9 reload count", cnt_out, 2);
        run_out(n, "R9 run");
        chk(n == 3, "R9 duration after reload", n, 3);

        // R10: full-scale hold
        cyc(1, 16383, 0, 0, 1, "R10 load");
        run_out(n, "R10 run");
        chk(n == 16384, "R10 full-scale duration", n, 16384);

        // random traffic against the bench model (R2 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            bit ld = ($urandom % 100) < 5;
            bit wr = ($urandom % 100) < 8;
            bit en = ($urandom % 100) < 80;
            int lv = $urandom % 40;
            int wv = (($urandom % 4) == 0) ? 0 : ($urandom % 20);
            cyc(ld, lv, wr, wv, en, "R2 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule